// File: doc/BRIEF.md
# Coherent Split Result Register

This block sits between a conversion engine and a byte-wide read bus. A completed conversion delivers a 10-bit result. The block stores it as two byte registers: a low byte with result bits 7:0, and a high byte with bits 9:8 in its two lowest positions and zeros above them. Software reads the low byte first and the high byte second. The block makes sure that both bytes of that pair come from the same conversion.

When the low byte is read, the block freezes both registers. A conversion that finishes while they are frozen is dropped, and the registers keep the pair that software is reading. Reading the high byte lifts the freeze. Every completed conversion sets an interrupt flag, whether its result was stored or dropped. Software clears the flag by writing 1 to it.

Top module: `res_coherent_split`

## Requirements
- R1: A synchronous active-high reset clears the low and high byte outputs to 0, clears the interrupt flag and leaves the registers unfrozen.
- R2: When the registers are unfrozen and no low byte read happens in the same cycle, a done strobe stores the result. On the next cycle the low output equals result[7:0], and the high output equals {6'b0, result[9:8]}.
- R3: A low byte read freezes both registers from that cycle onward. A done strobe in the read cycle, or in any later cycle before a high byte read, changes neither output.
- R4: The interrupt flag is 1 in the cycle after every done strobe, including a strobe whose result was dropped by the freeze.
- R5: A high byte read lifts the freeze, so a done strobe in a later cycle stores its result as in R2.
- R6: When a done strobe and a high byte read fall in the same cycle while the registers are frozen, the freeze is lifted first and the new result is stored.
- R7: A high byte read with no low byte read before it leaves the registers unfrozen.
- R8: Writing 1 to the flag clear input clears the interrupt flag on the next cycle. When a done strobe falls in the same cycle, the flag is set instead.
- R9: A low byte read and a high byte read in the same cycle leave the registers unfrozen, and a done strobe in that same cycle is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Conversion-complete strobe |
| result_i | input | 10 | Conversion result, valid with done_i |
| rd_lo_i | input | 1 | Read strobe for the low byte register |
| rd_hi_i | input | 1 | Read strobe for the high byte register |
| irq_clr_i | input | 1 | Write-1 clear of the interrupt flag |
| lo_o | output | 8 | Low byte register value |
| hi_o | output | 8 | High byte register value |
| irq_o | output | 1 | Conversion-complete interrupt flag |

## Verification
Two pairs of events can fall in the same cycle. The first is a done strobe together with a high byte read that lifts the freeze. The second is a done strobe together with a flag clear. Directed sequences place each pair on one clock edge, and a long random run then overlaps strobes freely. A per-cycle reference model built from the requirements judges the result: for the first pair, whether the new result is stored or dropped, and for the second, whether the flag ends up set.

// File: rtl/res_lock_pkg.sv
package res_lock_pkg;

    parameter int RES_W  = 10;
    parameter int BYTE_W = 8;
    localparam int HI_W  = RES_W - BYTE_W;

    typedef enum logic {
        ST_OPEN   = 1'b0,
        ST_FROZEN = 1'b1
    } lock_state_t;

    typedef struct packed {
        logic [BYTE_W-1:0] hi;
        logic [BYTE_W-1:0] lo;
    } byte_pair_t;

    function automatic byte_pair_t split_result(input logic [RES_W-1:0] res);
        byte_pair_t p;
        p.lo = res[BYTE_W-1:0];
        p.hi = '0;
        p.hi[HI_W-1:0] = res[RES_W-1:BYTE_W];
        return p;
    endfunction

endpackage

// File: rtl/res_lock_ctrl.sv
module res_lock_ctrl
    import res_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        done,
    input  logic        rd_lo,
    input  logic        rd_hi,
    output logic        wr_en,
    output lock_state_t state
);

    lock_state_t state_q;
    lock_state_t state_d;
    logic        blocked;

    // A high read always releases; a low read freezes starting in its own cycle.
    always_comb begin
        state_d = state_q;
        if (rd_hi) begin
            state_d = ST_OPEN;
        end else if (rd_lo) begin
            state_d = ST_FROZEN;
        end
    end

    always_comb begin
        blocked = ((state_q == ST_FROZEN) || rd_lo) && !rd_hi;
        wr_en   = done && !blocked;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_OPEN;
        end else begin
            state_q <= state_d;
        end
    end

    assign state = state_q;

endmodule

// File: rtl/res_lock_regs.sv
module res_lock_regs
    import res_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [RES_W-1:0] result,
    output byte_pair_t       pair
);

    byte_pair_t pair_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pair_q <= '0;
        end else if (wr_en) begin
            pair_q <= split_result(result);
        end
    end

    assign pair = pair_q;

endmodule

// File: rtl/res_lock_irq.sv
module res_lock_irq (
    input  logic clk,
    input  logic rst,
    input  logic set,
    input  logic clr,
    output logic flag
);

    logic flag_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= 1'b0;
        end else if (set) begin
            flag_q <= 1'b1;
        end else if (clr) begin
            flag_q <= 1'b0;
        end
    end

    assign flag = flag_q;

endmodule

// File: rtl/res_coherent_split.sv
module res_coherent_split
    import res_lock_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             done_i,
    input  logic [RES_W-1:0] result_i,
    input  logic             rd_lo_i,
    input  logic             rd_hi_i,
    input  logic             irq_clr_i,
    output logic [BYTE_W-1:0] lo_o,
    output logic [BYTE_W-1:0] hi_o,
    output logic             irq_o
);

    logic        wr_en;
    lock_state_t lock_state;
    logic        lock_q;
    byte_pair_t  pair;

    res_lock_ctrl u_ctrl (
        .clk   (clk),
        .rst   (rst),
        .done  (done_i),
        .rd_lo (rd_lo_i),
        .rd_hi (rd_hi_i),
        .wr_en (wr_en),
        .state (lock_state)
    );

    res_lock_regs u_regs (
        .clk    (clk),
        .rst    (rst),
        .wr_en  (wr_en),
        .result (result_i),
        .pair   (pair)
    );

    res_lock_irq u_irq (
        .clk  (clk),
        .rst  (rst),
        .set  (done_i),
        .clr  (irq_clr_i),
        .flag (irq_o)
    );

    assign lock_q = (lock_state == ST_FROZEN);
    assign lo_o   = pair.lo;
    assign hi_o   = pair.hi;

endmodule

// File: rtl/res_lock_chk.sv
module res_lock_chk
    import res_lock_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              done_i,
    input logic [RES_W-1:0]  result_i,
    input logic              rd_lo_i,
    input logic              rd_hi_i,
    input logic              irq_clr_i,
    input logic [BYTE_W-1:0] lo_o,
    input logic [BYTE_W-1:0] hi_o,
    input logic              irq_o,
    input logic              lock_q
);

    assert_store_R2: assert property (@(posedge clk) disable iff (rst)
        (done_i && !lock_q && !rd_lo_i) |=>
            (lo_o == $past(result_i[BYTE_W-1:0]) &&
             hi_o[HI_W-1:0] == $past(result_i[RES_W-1:BYTE_W])));

    assert_hi_zero_R2: assert property (@(posedge clk) disable iff (rst)
        hi_o[BYTE_W-1:HI_W] == '0);

    assert_frozen_hold_R3: assert property (@(posedge clk) disable iff (rst)
        ((lock_q || rd_lo_i) && !rd_hi_i) |=> ($stable(lo_o) && $stable(hi_o)));

    assert_irq_set_R4: assert property (@(posedge clk) disable iff (rst)
        done_i |=> irq_o);

    assert_release_R7: assert property (@(posedge clk) disable iff (rst)
        rd_hi_i |=> !lock_q);

    assert_irq_clear_R8: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_i && !done_i) |=> !irq_o);

endmodule

bind res_coherent_split res_lock_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .done_i    (done_i),
    .result_i  (result_i),
    .rd_lo_i   (rd_lo_i),
    .rd_hi_i   (rd_hi_i),
    .irq_clr_i (irq_clr_i),
    .lo_o      (lo_o),
    .hi_o      (hi_o),
    .irq_o     (irq_o),
    .lock_q    (lock_q)
);

// File: tb/tb_res_coherent_split.sv
module tb_res_coherent_split;

    logic       clk = 1'b0;
    logic       rst;
    logic       done_i;
    logic [9:0] result_i;
    logic       rd_lo_i;
    logic       rd_hi_i;
    logic       irq_clr_i;
    logic [7:0] lo_o;
    logic [7:0] hi_o;
    logic       irq_o;

    int total = 0;
    int bad   = 0;

    logic [7:0] m_lo, m_hi;
    logic       m_lock, m_irq;

    always #2.5 clk = ~clk;

    res_coherent_split dut (
        .clk(clk), .rst(rst), .done_i(done_i), .result_i(result_i),
        .rd_lo_i(rd_lo_i), .rd_hi_i(rd_hi_i), .irq_clr_i(irq_clr_i),
        .lo_o(lo_o), .hi_o(hi_o), .irq_o(irq_o)
    );

    function automatic logic [7:0] exp_hi_of(input logic [9:0] r);
        return {6'b0, r[9:8]};
    endfunction

    task automatic check(input string tag, input logic [7:0] lo_e,
                         input logic [7:0] hi_e, input logic irq_e);
        total++;
        if (lo_o !== lo_e || hi_o !== hi_e || irq_o !== irq_e) begin
            bad++;
            $display("FAIL %s: lo=%h hi=%h irq=%b expected lo=%h hi=%h irq=%b",
                     tag, lo_o, hi_o, irq_o, lo_e, hi_e, irq_e);
        end
    endtask

    // One cycle of stimulus: drive after a falling edge, advance the model at
    // the rising edge, then compare at the next falling edge.
    task automatic step(input logic d, input logic [9:0] r, input logic rl,
                        input logic rh, input logic c, input string tag);
        logic blocked;
        done_i = d; result_i = r; rd_lo_i = rl; rd_hi_i = rh; irq_clr_i = c;
        @(posedge clk);
        blocked = (m_lock || rl) && !rh;
        if (d && !blocked) begin
            m_lo = r[7:0];
            m_hi = exp_hi_of(r);
        end
        m_lock = rh ? 1'b0 : (rl ? 1'b1 : m_lock);
        m_irq  = d ? 1'b1 : (c ? 1'b0 : m_irq);
        @(negedge clk);
        done_i = 0; rd_lo_i = 0; rd_hi_i = 0; irq_clr_i = 0;
        check(tag, m_lo, m_hi, m_irq);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5EED_1234));
        rst = 1; done_i = 0; result_i = '0; rd_lo_i = 0; rd_hi_i = 0; irq_clr_i = 0;
        m_lo = 0; m_hi = 0; m_lock = 0; m_irq = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        check("R1 reset state", 8'h00, 8'h00, 1'b0);

        // R2 plain store, bits 9:8 into high byte, zeros above
        step(1, 10'h2A5, 0, 0, 0, "R2 store");
        check("R2 explicit", 8'hA5, 8'h02, 1'b1);
        step(0, 0, 0, 0, 1, "R8 clear");
        check("R8 explicit clear", 8'hA5, 8'h02, 1'b0);

        // R3/R4 freeze and dropped result still sets flag
        step(0, 0, 1, 0, 0, "R3 low read");
        step(1, 10'h3FF, 0, 0, 0, "R3 R4 dropped");
        check("R4 explicit", 8'hA5, 8'h02, 1'b1);

        // R5 release then store
        step(0, 0, 0, 1, 0, "R5 high read");
        step(1, 10'h155, 0, 0, 0, "R5 store after release");
        check("R5 explicit", 8'h55, 8'h01, 1'b1);

        // R6 done in same cycle as releasing high read
        step(0, 0, 1, 0, 0, "R6 setup low read");
        step(1, 10'h0F0, 0, 1, 0, "R6 same-cycle release");
        check("R6 explicit", 8'hF0, 8'h00, 1'b1);

        // R7 lone high read does not freeze
        step(0, 0, 0, 1, 0, "R7 lone high read");
        step(1, 10'h1C3, 0, 0, 0, "R7 store");
        check("R7 explicit", 8'hC3, 8'h01, 1'b1);

        // R3 done in the low read cycle is dropped
        step(1, 10'h200, 1, 0, 0, "R3 same-cycle low read");
        check("R3 explicit", 8'hC3, 8'h01, 1'b1);
        step(0, 0, 0, 1, 0, "R5 release again");

        // R9 both reads together with done
        step(1, 10'h37E, 1, 1, 0, "R9 both reads");
        check("R9 explicit", 8'h7E, 8'h03, 1'b1);
        step(1, 10'h011, 0, 0, 0, "R9 stays open");
        check("R9 open after", 8'h11, 8'h00, 1'b1);

        // R8 set wins over clear
        step(1, 10'h022, 0, 0, 1, "R8 set beats clear");
        check("R8 explicit set wins", 8'h22, 8'h00, 1'b1);

        // Random mix covering R2..R9
        for (int i = 0; i < 3000; i++) begin
            step(($urandom % 3) == 0, 10'($urandom), ($urandom % 5) == 0,
                 ($urandom % 6) == 0, ($urandom % 4) == 0, "R2-R9 random");
        end

        // R1 reset from a busy state
        step(0, 0, 1, 0, 0, "R1 pre-reset low read");
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        rst = 0;
        m_lo = 0; m_hi = 0; m_lock = 0; m_irq = 0;
        check("R1 reset again", 8'h00, 8'h00, 1'b0);
        step(1, 10'h3A9, 0, 0, 0, "R1 unfrozen after reset");
        check("R1 explicit store", 8'hA9, 8'h03, 1'b1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule